// File: doc/BRIEF.md
# Memory Bank Decoder with Byte-Lane Write Strobes

This block sits between a 32-bit processor's load/store path and its external memory bus. Each cycle it may take one request: a byte address, an access size (byte, halfword or word) and a read/write flag. From that it selects one of eight external memory banks. Each bank spans a 128 MB window, so together they cover the lowest 1 GB of the address map. The block drives an active-low chip select for the chosen bank, a 27-bit external address, and four active-low byte-lane write strobes for the 32-bit data bus.

Some requests are faults: a halfword or word access that is not naturally aligned, a request with the reserved size code, and any address above the first gigabyte. The last case includes the on-chip register space at 0x48000000 to 0x5FFFFFFF. A faulting request produces a one-cycle fault pulse and no strobe at all. All outputs are registered, so the bus sees the decode one clock after the request.

Top module: `mem_bank_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every bank select and lane strobe is high, fault is low and the external address is zero.
- R2: A valid, non-faulting request with address bits [31:30] equal to zero drives low exactly the bank select indexed by address bits [29:27] in the next cycle. All other bank selects stay high.
- R3: A valid request whose address bits [31:30] are not zero is a fault. This includes the register space 0x48000000 to 0x5FFFFFFF.
- R4: A byte write (size code 0) drives low only the lane strobe whose index equals address bits [1:0].
- R5: A halfword write (size code 1) at offset 0 drives lanes 1 and 0 low. At offset 2 it drives lanes 3 and 2 low.
- R6: A halfword request with address bit 0 set is a fault.
- R7: A word request (size code 2) is a fault unless address bits [1:0] are zero. An aligned word write drives all four lane strobes low.
- R8: Size code 3 is reserved, and any request that uses it is a fault.
- R9: For a faulting request, the fault output is high for exactly the next cycle, and all bank selects and lane strobes stay high in that cycle.
- R10: A non-faulting read asserts its bank select but leaves all four lane strobes high.
- R11: The external address takes address bits [26:0] one cycle after each non-faulting request. It holds its value across idle cycles and faulting requests.
- R12: A cycle with no valid request is followed by a cycle with every bank select and lane strobe high and fault low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_write | input | 1 | 1 write, 0 read |
| bank_cs_n | output | 8 | Per-bank chip selects, active low |
| lane_we_n | output | 4 | Byte-lane write strobes, active low |
| ext_addr | output | 27 | External byte address |
| fault | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench sweeps every combination of bank, low-order offset, size code and direction. This separates bank indexing errors from lane-mask errors, and separates alignment rules per size from the read/write gating of strobes. It also runs addresses with each non-zero top-two-bit pattern, and the edges of the register space, which show whether the range check and the bank index share the right bits. Idle cycles placed between a faulting request and a good request show whether the external address is held and whether the fault lasts only one cycle.

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder #(
  parameter int ADDR_W    = 32,
  parameter int EXT_W     = 27,
  parameter int NUM_BANKS = 8,
  parameter int LANES     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_write,
  output logic [NUM_BANKS-1:0] bank_cs_n,
  output logic [LANES-1:0]     lane_we_n,
  output logic [EXT_W-1:0]     ext_addr,
  output logic                 fault
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int OFF_W  = $clog2(LANES);
  localparam int TOP_LO = EXT_W + BANK_W;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  logic [BANK_W-1:0]    bank_idx;
  logic [OFF_W-1:0]     offset;
  logic                 in_range;
  logic                 misaligned;
  logic                 bad;
  logic [LANES-1:0]     lane_mask;
  logic [NUM_BANKS-1:0] cs_nxt;
  logic [LANES-1:0]     we_nxt;

  assign bank_idx = req_addr[TOP_LO-1:EXT_W];
  assign offset   = req_addr[OFF_W-1:0];
  assign in_range = (req_addr[ADDR_W-1:TOP_LO] == '0);

  always_comb begin
    misaligned = 1'b0;
    lane_mask  = '0;
    unique case (req_size)
      SZ_BYTE: lane_mask = LANES'(1) << offset;
      SZ_HALF: begin
        misaligned = offset[0];
        lane_mask  = LANES'(3) << {offset[OFF_W-1:1], 1'b0};
      end
      SZ_WORD: begin
        misaligned = (offset != '0);
        lane_mask  = '1;
      end
      default: misaligned = 1'b1;
    endcase
  end

  assign bad    = req_valid && (!in_range || misaligned);
  assign cs_nxt = (req_valid && !bad) ? ~(NUM_BANKS'(1) << bank_idx) : '1;
  assign we_nxt = (req_valid && !bad && req_write) ? ~lane_mask : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_cs_n <= '1;
      lane_we_n <= '1;
      ext_addr  <= '0;
      fault     <= 1'b0;
    end else begin
      bank_cs_n <= cs_nxt;
      lane_we_n <= we_nxt;
      fault     <= bad;
      if (req_valid && !bad) ext_addr <= req_addr[EXT_W-1:0];
    end
  end

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bank_cs_n));

  // R3
  range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[ADDR_W-1:TOP_LO] != '0) |=> fault);

  // R8
  rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd3) |=> fault);

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (&bank_cs_n && &lane_we_n));

  // R10
  read_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> &lane_we_n);

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(ext_addr));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (&bank_cs_n && !fault));
endmodule

// File: tb/mem_bank_decoder_tb.sv
module mem_bank_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [7:0]  bank_cs_n;
  logic [3:0]  lane_we_n;
  logic [26:0] ext_addr;
  logic        fault;

  int tests = 0;
  int fails = 0;
  logic [26:0] exp_ext = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_bank_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .bank_cs_n(bank_cs_n),
    .lane_we_n(lane_we_n), .ext_addr(ext_addr), .fault(fault)
  );

  task automatic check(string tag, logic [7:0] ecs, logic [3:0] ewe, logic ef);
    tests++;
    if (bank_cs_n !== ecs || lane_we_n !== ewe || fault !== ef || ext_addr !== exp_ext) begin
      fails++;
      $display("FAIL %s: got cs=%h we=%h f=%b ea=%h, exp cs=%h we=%h f=%b ea=%h",
               tag, bank_cs_n, lane_we_n, fault, ext_addr, ecs, ewe, ef, exp_ext);
    end
  endtask

  task automatic req(logic [31:0] a, logic [1:0] sz, logic wr);
    logic bad;
    logic [3:0] m;
    logic [7:0] ecs;
    logic [3:0] ewe;
    string tag;
    bad = (a[31:30] != 2'b00) || (sz == 2'd3) ||
          (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00);
    m = (sz == 2'd0) ? (4'd1 << a[1:0]) :
        (sz == 2'd1) ? (4'd3 << {a[1], 1'b0}) : 4'hF;
    ecs = bad ? 8'hFF : ~(8'd1 << a[29:27]);
    ewe = (bad || !wr) ? 4'hF : ~m;
    if (a[31:30] != 2'b00) tag = "R3";
    else if (sz == 2'd3) tag = "R8";
    else if (bad && sz == 2'd1) tag = "R6";
    else if (sz == 2'd2) tag = "R7";
    else if (!wr) tag = "R10";
    else if (sz == 2'd1) tag = "R5";
    else tag = "R4";
    if (!bad) tag = {tag, "/R2/R11"}; else tag = {tag, "/R9"};
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    @(negedge clk);
    if (!bad) exp_ext = a[26:0];
    check(tag, ecs, ewe, bad);
  endtask

  task automatic idle();
    req_valid = 1'b0; req_addr = 32'hFFFF_FFFF; req_size = 2'd3; req_write = 1'b1;
    @(negedge clk);
    check("R12/R11", 8'hFF, 4'hF, 1'b0);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'hFF, 4'hF, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 8'hFF, 4'hF, 1'b0);
    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++)
          for (int w = 0; w < 2; w++)
            req({2'b00, 3'(b), 27'(((b * 7 + s) * 4099) << 2) | 27'(o)}, 2'(s), 1'(w));
    for (int t = 1; t < 4; t++)
      for (int s = 0; s < 3; s++) begin
        req({2'(t), 3'(s), 27'h155_5550}, 2'(s), 1'b1);
        idle();
      end
    req(32'h4800_0000, 2'd2, 1'b1);
    req(32'h5FFF_FFFC, 2'd2, 1'b0);
    req(32'h3FFF_FFFC, 2'd2, 1'b1);
    req(32'h0000_0003, 2'd2, 1'b1);
    idle();
    idle();
    req(32'h2000_0002, 2'd1, 1'b1);
    req(32'h2000_0001, 2'd1, 1'b1);
    idle();
    req(32'h0800_0001, 2'd0, 1'b1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule